// File: doc/BRIEF.md
# Transmit Checksum Insertion Engine

This block sits in the transmit path of an Ethernet interface. It takes an outgoing frame as a byte stream, computes a 16-bit ones'-complement checksum over part of the frame, and writes that checksum into the frame before sending it on. Software chooses, for each frame, where the summed region starts and where the result goes. It does this through a control word that arrives with the first byte. The engine does not parse any protocol headers.

The whole frame is held in an internal buffer. The engine sends nothing downstream until the last byte has arrived and the checksum is known. While the stored frame drains, the upstream side is held off. The checksum field itself lies inside the summed region. Software can therefore pre-load that field with a pseudo-header partial sum, and the engine folds it into the result.

A static input selects whether an all-zero result is replaced by 0xFFFF. UDP needs that replacement. It is off by default.

Top module: `tx_csum_stuffer`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: When control word bit 28 is 0, the frame leaves the engine byte for byte as it arrived, with the same length.
- R3: The checksum covers the bytes from the start offset (control word bits 19:14, counted in bytes from the first frame byte) through the last byte of the frame.
  - The bytes are taken as big-endian 16-bit words, and an odd final byte is padded with a zero low byte.
  - Carries are folded back in, and the folded sum is inverted.
- R4: When bit 28 is 1, the checksum replaces the byte at the insertion offset (bits 27:20) with its high byte and the following byte with its low byte.
  - The sum uses the bytes as they arrived.
  - A replaced position at or beyond the end of the frame has no effect.
- R5: A checksum of 0x0000 is sent as 0x0000 when `comp_zero` is 0, and as 0xFFFF when `comp_zero` is 1.
- R6: Output of a frame starts only after its last input byte has been accepted. `in_ready` stays low from that point until the last output byte is accepted.
- R7: `out_first` marks output byte 0 and `out_last` marks the final byte. While `out_ready` is low, `out_valid` and the output byte and markers hold steady.
- R8: Control word bits 13:0 (length) are ignored. The frame length comes only from `in_last`, for frames of up to `BUF_BYTES` bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| comp_zero | input | 1 | Send a zero checksum as 0xFFFF |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Engine can take an input byte |
| in_data | input | 8 | Input byte |
| in_first | input | 1 | First byte of a frame |
| in_last | input | 1 | Last byte of a frame |
| in_desc | input | 32 | Per-frame control word, sampled with the first byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream takes the byte |
| out_data | output | 8 | Output byte |
| out_first | output | 1 | First output byte of a frame |
| out_last | output | 1 | Last output byte of a frame |

## Verification
The hardest case to reach from the ports is a checksum that folds to exactly zero. It is the only case where `comp_zero` changes the output.

The stimulus reaches it with frames whose summed region holds only 0xFF bytes. Such a region sums to 0xFFFF, which inverts to zero. These frames are sent with both settings of `comp_zero`.

A sweep also covers these arrangements, over many frame lengths and start and insertion offsets:
- insertion offsets that straddle the final byte;
- insertion offsets that fall past the end of the frame;
- insertion offsets that lie before the start offset;
- odd-length summed regions.

// File: rtl/tx_csum_stuffer.sv
module tx_csum_stuffer #(
  parameter int BUF_BYTES = 2048
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       comp_zero,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_first,
  input  logic       in_last,
  input  logic [31:0] in_desc,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_first,
  output logic       out_last
);
  localparam int AW = $clog2(BUF_BYTES);
  localparam int START_LSB = 14;
  localparam int STUFF_LSB = 20;
  localparam int EN_BIT = 28;

  logic [7:0]    mem [BUF_BYTES];
  logic          draining, en_q;
  logic [AW-1:0] wptr, rptr, last_idx;
  logic [5:0]    start_q;
  logic [7:0]    stuff_q;
  logic [31:0]   acc;

  wire unused_desc = ^{in_desc[13:0], in_desc[31:29]};

  wire          take   = in_valid && in_ready;
  wire [AW-1:0] idx    = in_first ? '0 : wptr;
  wire [5:0]    st     = in_first ? in_desc[START_LSB +: 6] : start_q;
  wire [AW-1:0] st_ext = {{(AW-6){1'b0}}, st};
  wire [AW-1:0] rel    = idx - st_ext;
  wire          in_reg = idx >= st_ext;
  wire [31:0]   addend = !in_reg ? 32'd0 :
                         rel[0]  ? {24'd0, in_data} : {16'd0, in_data, 8'd0};
  wire [31:0]   acc_base = in_first ? 32'd0 : acc;

  wire [16:0] f1   = {1'b0, acc[15:0]} + {1'b0, acc[31:16]};
  wire [15:0] f2   = f1[15:0] + {15'd0, f1[16]};
  wire [15:0] inv  = ~f2;
  wire [15:0] csum = (comp_zero && inv == 16'h0000) ? 16'hFFFF : inv;

  wire [AW-1:0] stuff_ext = {{(AW-8){1'b0}}, stuff_q};
  wire hit_hi = en_q && rptr == stuff_ext;
  wire hit_lo = en_q && rptr == stuff_ext + 1'b1;

  assign in_ready  = !draining;
  assign out_valid = draining;
  assign out_first = draining && rptr == '0;
  assign out_last  = draining && rptr == last_idx;
  assign out_data  = hit_hi ? csum[15:8] : hit_lo ? csum[7:0] : mem[rptr];

  always_ff @(posedge clk)
    if (take) mem[idx] <= in_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      draining <= 1'b0;
      en_q     <= 1'b0;
      wptr     <= '0;
      rptr     <= '0;
      last_idx <= '0;
      start_q  <= '0;
      stuff_q  <= '0;
      acc      <= '0;
    end else if (!draining) begin
      if (take) begin
        wptr <= idx + 1'b1;
        acc  <= acc_base + addend;
        if (in_first) begin
          start_q <= in_desc[START_LSB +: 6];
          stuff_q <= in_desc[STUFF_LSB +: 8];
          en_q    <= in_desc[EN_BIT];
        end
        if (in_last) begin
          last_idx <= idx;
          draining <= 1'b1;
          rptr     <= '0;
        end
      end
    end else if (out_ready) begin
      if (rptr == last_idx) begin
        draining <= 1'b0;
        rptr     <= '0;
      end else begin
        rptr <= rptr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tx_csum_stuffer_chk.sv
module tx_csum_stuffer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       in_last,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_first,
  input logic       out_last
);
  a_r6_no_input_while_draining: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  a_r6_release_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last) |=> (out_valid && out_first));

  a_r6_reopen_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> (in_ready && !out_valid));

  a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
                                   $stable(out_first) && $stable(out_last)));
endmodule

bind tx_csum_stuffer tx_csum_stuffer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_last(in_last), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_first(out_first), .out_last(out_last)
);

// File: tb/sim_tx_csum_stuffer.sv
module sim_tx_csum_stuffer;
  logic clk = 1'b0, rst_n = 1'b0, comp_zero = 1'b0;
  logic in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0, out_ready = 1'b0;
  logic [7:0] in_data = '0;
  logic [31:0] in_desc = '0;
  logic in_ready, out_valid, out_first, out_last;
  logic [7:0] out_data;

  int total = 0, bad = 0, cyc = 0;
  logic [7:0] frm [2048];
  logic [7:0] exp_b [2048];
  logic [7:0] got [2048];
  int got_n;
  logic mark_ok, stall_ok;

  always #2 clk = ~clk;

  tx_csum_stuffer u0 (
    .clk(clk), .rst_n(rst_n), .comp_zero(comp_zero),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_first(in_first), .in_last(in_last), .in_desc(in_desc),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_first(out_first), .out_last(out_last)
  );

  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    wait (cyc > 150000);
    total++; bad++;
    $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic logic [15:0] ref_csum(int n, int st, logic cz);
    logic [31:0] s = 0;
    logic [15:0] r;
    for (int i = st; i < n; i++)
      s += ((i - st) % 2 == 0) ? {16'd0, frm[i], 8'd0} : {24'd0, frm[i]};
    while (s[31:16] != 0) s = {16'd0, s[15:0]} + {16'd0, s[31:16]};
    r = ~s[15:0];
    if (cz && r == 16'h0000) r = 16'hFFFF;
    return r;
  endfunction

  task automatic send_frame(int n, logic [31:0] d);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1; in_data = frm[i]; in_desc = d;
      in_first = (i == 0); in_last = (i == n - 1);
    end
    @(negedge clk);
    in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
  endtask

  task automatic recv_frame();
    int k = 0;
    bit done = 0;
    got_n = 0; mark_ok = 1'b1; stall_ok = 1'b1;
    while (!done) begin
      out_ready = ((cyc * 7 + k) % 3) != 0;
      #0;
      if (out_valid && in_ready) stall_ok = 1'b0;
      if (out_valid && out_ready) begin
        got[got_n] = out_data;
        if (out_first != (got_n == 0)) mark_ok = 1'b0;
        if (out_last) done = 1;
        got_n++;
      end
      k++;
      @(negedge clk);
      if (got_n > 2100) done = 1;
    end
    out_ready = 1'b0;
  endtask

  task automatic run_frame(string tag, int n, int st, int sf, bit en, bit cz, int lenfield);
    logic [31:0] d;
    logic [15:0] c;
    int mism = -1;
    d = 32'd0;
    d[13:0] = 14'(lenfield);
    d[19:14] = 6'(st);
    d[27:20] = 8'(sf);
    d[28] = en;
    comp_zero = cz;
    c = ref_csum(n, st, cz);
    for (int i = 0; i < n; i++) exp_b[i] = frm[i];
    if (en && sf < n) exp_b[sf] = c[15:8];
    if (en && sf + 1 < n) exp_b[sf + 1] = c[7:0];
    send_frame(n, d);
    recv_frame();
    total++;
    if (got_n != n) begin
      bad++;
      $display("FAIL %s R8: frame length actual=%0d expected=%0d", tag, got_n, n);
    end else begin
      for (int i = 0; i < n; i++) if (mism < 0 && got[i] !== exp_b[i]) mism = i;
      if (mism >= 0) begin
        bad++;
        $display("FAIL %s: n=%0d st=%0d sf=%0d en=%0b byte %0d actual=%02h expected=%02h",
                 tag, n, st, sf, en, mism, got[mism], exp_b[mism]);
      end
    end
    total++;
    if (!mark_ok || !stall_ok) begin
      bad++;
      $display("FAIL R6/R7 markers: actual first_ok=%0b ready_low_ok=%0b expected=1 1",
               mark_ok, stall_ok);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (in_ready !== 1'b1 || out_valid !== 1'b0) begin
      bad++;
      $display("FAIL R1 reset: actual ready=%0b valid=%0b expected=1 0", in_ready, out_valid);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R2: pass-through with enable clear
    for (int n = 1; n <= 20; n++) begin
      for (int i = 0; i < n; i++) frm[i] = 8'((i * 29 + n * 5) & 8'hFF);
      run_frame("R2 passthrough", n, n % 7, 2, 1'b0, 1'b0, n);
    end

    // R3/R4 sweep over length, start offset and insertion offset
    for (int n = 2; n <= 26; n++)
      for (int si = 0; si < 4; si++)
        for (int fi = 0; fi < 3; fi++) begin
          int st, sf;
          st = (si == 0) ? 0 : (si == 1) ? 1 : (si == 2) ? 3 : 5;
          if (st >= n) st = n - 1;
          sf = (fi == 0) ? st : (fi == 1) ? n - 1 : n + 1;
          for (int i = 0; i < n; i++) frm[i] = 8'((i * 37 + n * 11 + st) & 8'hFF);
          run_frame("R3/R4 sweep", n, st, sf, 1'b1, 1'b0, 0);
        end

    // R4: insertion offset before the start offset
    for (int i = 0; i < 30; i++) frm[i] = 8'(i + 100);
    run_frame("R4 stuff-before-start", 30, 10, 2, 1'b1, 1'b0, 30);

    // R5: zero result, with and without compensation
    for (int cz = 0; cz < 2; cz++) begin
      frm[0] = 8'h12; frm[1] = 8'h34; frm[2] = 8'hFF; frm[3] = 8'hFF;
      frm[4] = 8'hFF; frm[5] = 8'hFF;
      run_frame(cz ? "R5 zero comp on" : "R5 zero comp off", 6, 2, 4, 1'b1, cz[0], 6);
      frm[0] = 8'hFF; frm[1] = 8'hFF;
      run_frame(cz ? "R5 zero 2B comp on" : "R5 zero 2B comp off", 2, 0, 0, 1'b1, cz[0], 2);
    end

    // R8: full-size frame, wrong length field
    for (int i = 0; i < 1518; i++) frm[i] = 8'((i * 13 + 7) & 8'hFF);
    frm[50] = 8'h00; frm[51] = 8'h00;
    run_frame("R8 1518B", 1518, 34, 50, 1'b1, 1'b1, 60);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule